// File: doc/BRIEF.md
# Expansion Memory Address Translator

This block sits between an 8-bit CPU's 16-bit address bus and a 512 KB SRAM plus a 512 KB flash device. Each cycle it checks whether the CPU address falls inside one of five expansion windows. If it does, it forms a 19-bit memory address, picks which chip is selected and decides whether a write strobe is issued. All outputs come from a single register stage, so they appear one clock after the inputs.

The memory is divided into 32 KB banks, and each window lands in an 8 KB slot of a bank. The chosen bank and chip depend on the operating mode, on a 5-bit steering field and on the access direction. Because reads and writes for the same window can go to different banks, the block can present a cartridge image that ignores overwrites. It can also expose a second bank for reads while all writes still reach the first bank.

Configuration arrives on plain inputs: mode, steering bits, per-window disable bits and two address-bit flips. Decoding the configuration registers happens elsewhere.

Top module: `exp_addr_xlat`

## Requirements
- R1: While rst_n is low, and after rst_n rises until the first rising clock edge, hit, sram_ce, flash_ce, mem_we and mem_addr are all 0.
- R2: Every output shows the translation of the inputs sampled at the previous rising clock edge. The latency is exactly one cycle.
- R3: There are five windows, indexed 0 to 4: $0400-$0FFF, $2000-$3FFF, $4000-$5FFF, $6000-$7FFF and $A000-$BFFF. An address outside all of them never raises hit, a chip select or mem_we. A chip select is only ever raised together with hit.
- R4: Window i is disabled when blk_off[i] is 1. An access to a disabled window raises neither hit, nor a chip select, nor mem_we.
- R5: In boot mode (mode_sel 000) only window 4 is decoded. A read selects flash at address {4'd0, 2'b11, a[12:0]}. A write selects SRAM with mem_we at {4'd1, 2'b11, a[12:0]}. The flip inputs have no effect in this mode.
- R6: In write-steer mode (100), reads to windows 1-4 use SRAM bank 1. A write to window i goes to bank 1 when info_bits[i] is 0 and to bank 2 when it is 1.
- R7: In read-steer mode (110), writes to windows 1-4 use SRAM bank 1. A read from window i uses bank 1 when info_bits[i] is 0 and bank 2 when it is 1.
- R8: In modes 100 and 110, window 0 uses SRAM bank 0. When info_bits[0] is 0, a write to it raises hit but no chip select and no mem_we.
- R9: In flash mode (001), every enabled window selects flash in bank info_bits[3:0]. mem_we follows cpu_wr.
- R10: Outside boot mode, mem_addr[18:15] is the bank and mem_addr[14:0] is {a[14]^flip_a14, a[13]^flip_a13, a[12:0]}.
- R11: The mode codes 010, 011, 101 and 111 decode nothing: hit, chip selects and mem_we stay 0.
- R12: sram_ce and flash_ce are never both 1. mem_we is only 1 together with a chip select. mem_addr is 0 whenever neither chip select is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | 1 = write access, 0 = read access |
| mode_sel | input | 3 | Operating mode code |
| info_bits | input | 5 | Per-window steering / write-enable / flash bank field |
| blk_off | input | 5 | Per-window disable, 1 = off |
| flip_a13 | input | 1 | Invert address bit 13 when forming the bank offset |
| flip_a14 | input | 1 | Invert address bit 14 when forming the bank offset |
| sram_ce | output | 1 | SRAM chip select |
| flash_ce | output | 1 | Flash chip select |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 19 | Translated memory address |
| hit | output | 1 | Access claimed by the expansion |

## Verification
A wrong window decode, a wrong bank choice or a wrong steering decision shows up at the ports one clock after the offending access. It appears as a wrong hit flag, a wrong chip select or a wrong bank field in mem_addr. Read and write traffic to the same window is compared per bank, so a swapped steering bit changes mem_addr[18:15] on the very next cycle. A protection fault appears as a stray mem_we on that same cycle. The block keeps no state beyond its output register, so no error can hide for more than one cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int CPU_AW  = 16;
  localparam int MEM_AW  = 19;
  localparam int OFF_AW  = 15;
  localparam int BANK_W  = MEM_AW - OFF_AW;
  localparam int SLOT_AW = 13;
  localparam int NWIN    = 5;
  localparam int BOOT_WIN = NWIN - 1;

  localparam logic [2:0] MODE_BOOT  = 3'b000;
  localparam logic [2:0] MODE_FLASH = 3'b001;
  localparam logic [2:0] MODE_WSTR  = 3'b100;
  localparam logic [2:0] MODE_RSTR  = 3'b110;

  function automatic logic [CPU_AW-1:0] win_lo(input int i);
    case (i)
      0: win_lo = 16'h0400;
      1: win_lo = 16'h2000;
      2: win_lo = 16'h4000;
      3: win_lo = 16'h6000;
      default: win_lo = 16'hA000;
    endcase
  endfunction

  function automatic logic [CPU_AW-1:0] win_hi(input int i);
    case (i)
      0: win_hi = 16'h0FFF;
      1: win_hi = 16'h3FFF;
      2: win_hi = 16'h5FFF;
      3: win_hi = 16'h7FFF;
      default: win_hi = 16'hBFFF;
    endcase
  endfunction

  function automatic logic [OFF_AW-1:0] bank_offset(input logic [OFF_AW-1:0] a,
                                                   input logic f13, input logic f14);
    bank_offset = {a[14] ^ f14, a[13] ^ f13, a[SLOT_AW-1:0]};
  endfunction

  function automatic logic [OFF_AW-1:0] boot_offset(input logic [OFF_AW-1:0] a);
    boot_offset = {2'b11, a[SLOT_AW-1:0]};
  endfunction
endpackage

// File: rtl/xlat_win_dec.sv
module xlat_win_dec
  import xlat_pkg::*;
(
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic [NWIN-1:0]   win_oh
);
  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign win_oh[i] = (cpu_addr >= win_lo(i)) && (cpu_addr <= win_hi(i));
  end
endmodule

// File: rtl/xlat_route.sv
module xlat_route
  import xlat_pkg::*;
(
  input  logic [NWIN-1:0]   win_oh,
  input  logic              cpu_wr,
  input  logic [2:0]        mode_sel,
  input  logic [NWIN-1:0]   info_bits,
  input  logic [NWIN-1:0]   blk_off,
  output logic              claim,
  output logic              pick_sram,
  output logic              pick_flash,
  output logic              wr_ok,
  output logic              fixed_slot,
  output logic [BANK_W-1:0] bank
);
  logic live, steer, is_w0, blocked;

  assign live  = |(win_oh & ~blk_off);
  assign steer = |(win_oh & info_bits);
  assign is_w0 = win_oh[0];

  always_comb begin
    claim = 1'b0;
    pick_sram = 1'b0;
    pick_flash = 1'b0;
    wr_ok = 1'b0;
    fixed_slot = 1'b0;
    bank = '0;
    blocked = 1'b0;
    case (mode_sel)
      MODE_BOOT: begin
        claim = live && win_oh[BOOT_WIN];
        fixed_slot = 1'b1;
        if (cpu_wr) begin
          pick_sram = claim;
          wr_ok = claim;
          bank = BANK_W'(1);
        end else begin
          pick_flash = claim;
        end
      end
      MODE_FLASH: begin
        claim = live;
        pick_flash = live;
        wr_ok = live && cpu_wr;
        bank = info_bits[BANK_W-1:0];
      end
      MODE_WSTR, MODE_RSTR: begin
        claim = live;
        if (is_w0) begin
          blocked = cpu_wr && !info_bits[0];
          bank = '0;
        end else if (cpu_wr == (mode_sel == MODE_WSTR)) begin
          bank = steer ? BANK_W'(2) : BANK_W'(1);
        end else begin
          bank = BANK_W'(1);
        end
        pick_sram = live && !blocked;
        wr_ok = live && !blocked && cpu_wr;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xlat_out_reg.sv
module xlat_out_reg
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim_d,
  input  logic              sram_d,
  input  logic              flash_d,
  input  logic              we_d,
  input  logic [MEM_AW-1:0] addr_d,
  output logic              hit,
  output logic              sram_ce,
  output logic              flash_ce,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      sram_ce  <= 1'b0;
      flash_ce <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
    end else begin
      hit      <= claim_d;
      sram_ce  <= sram_d;
      flash_ce <= flash_d;
      mem_we   <= we_d;
      mem_addr <= (sram_d || flash_d) ? addr_d : '0;
    end
  end
endmodule

// File: rtl/exp_addr_xlat.sv
module exp_addr_xlat
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_wr,
  input  logic [2:0]        mode_sel,
  input  logic [4:0]        info_bits,
  input  logic [4:0]        blk_off,
  input  logic              flip_a13,
  input  logic              flip_a14,
  output logic              sram_ce,
  output logic              flash_ce,
  output logic              mem_we,
  output logic [18:0]       mem_addr,
  output logic              hit
);
  logic [NWIN-1:0]   win_oh;
  logic              claim, pick_sram, pick_flash, wr_ok, fixed_slot;
  logic [BANK_W-1:0] bank;
  logic [OFF_AW-1:0] offset;
  logic [MEM_AW-1:0] addr_next;

  xlat_win_dec u_dec (
    .cpu_addr (cpu_addr),
    .win_oh   (win_oh)
  );

  xlat_route u_route (
    .win_oh     (win_oh),
    .cpu_wr     (cpu_wr),
    .mode_sel   (mode_sel),
    .info_bits  (info_bits),
    .blk_off    (blk_off),
    .claim      (claim),
    .pick_sram  (pick_sram),
    .pick_flash (pick_flash),
    .wr_ok      (wr_ok),
    .fixed_slot (fixed_slot),
    .bank       (bank)
  );

  assign offset = fixed_slot ? boot_offset(cpu_addr[OFF_AW-1:0])
                             : bank_offset(cpu_addr[OFF_AW-1:0], flip_a13, flip_a14);
  assign addr_next = {bank, offset};

  xlat_out_reg u_oreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .claim_d  (claim),
    .sram_d   (pick_sram),
    .flash_d  (pick_flash),
    .we_d     (wr_ok),
    .addr_d   (addr_next),
    .hit      (hit),
    .sram_ce  (sram_ce),
    .flash_ce (flash_ce),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
  );
endmodule

// File: rtl/xlat_chk.sv
module xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_wr,
  input logic [2:0]  mode_sel,
  input logic [4:0]  info_bits,
  input logic [4:0]  blk_off,
  input logic [4:0]  win_oh,
  input logic        sram_ce,
  input logic        flash_ce,
  input logic        mem_we,
  input logic [18:0] mem_addr,
  input logic        hit
);
  AST_ONE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_ce && flash_ce)); // R12
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (sram_ce || flash_ce)); // R12
  AST_CE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_ce || flash_ce) |-> hit); // R3
  AST_DISABLED_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (|(win_oh & blk_off)) |=> !hit && !sram_ce && !flash_ce); // R4
  AST_UNDEF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'b010 || mode_sel == 3'b011 || mode_sel == 3'b101 || mode_sel == 3'b111)
    |=> !hit && !sram_ce && !flash_ce && !mem_we); // R11
  AST_BOOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'b000 && cpu_wr && cpu_addr[15:13] == 3'b101 && !blk_off[4])
    |=> sram_ce && mem_we && mem_addr[18:13] == 6'b000111); // R5
  AST_W0_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sel == 3'b100 || mode_sel == 3'b110) && cpu_wr && win_oh[0] && !blk_off[0] && !info_bits[0])
    |=> hit && !mem_we && !sram_ce); // R8
endmodule

bind exp_addr_xlat xlat_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .mode_sel(mode_sel), .info_bits(info_bits), .blk_off(blk_off), .win_oh(win_oh),
  .sram_ce(sram_ce), .flash_ce(flash_ce), .mem_we(mem_we), .mem_addr(mem_addr), .hit(hit)
);

// File: tb/exp_addr_xlat_tb_top.sv
module exp_addr_xlat_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic cpu_wr = 1'b0;
  logic [2:0] mode_sel = '0;
  logic [4:0] info_bits = '0, blk_off = '0;
  logic flip_a13 = 1'b0, flip_a14 = 1'b0;
  logic sram_ce, flash_ce, mem_we, hit;
  logic [18:0] mem_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic hit, sce, fce, we;
    logic [18:0] addr;
    string tag;
  } exp_t;
  exp_t sb[$];

  exp_addr_xlat dut_i (.*);

  always #4 clk = ~clk;

  function automatic exp_t model(logic [15:0] a, logic wr, logic [2:0] m,
                                 logic [4:0] inf, logic [4:0] off, logic f13, logic f14);
    exp_t e;
    int w;
    int bk;
    logic [14:0] o;
    e.hit = 0; e.sce = 0; e.fce = 0; e.we = 0; e.addr = '0; e.tag = "R3";
    w = -1;
    if (a >= 16'h0400 && a < 16'h1000) w = 0;
    else if (a >= 16'h2000 && a < 16'h4000) w = 1;
    else if (a >= 16'h4000 && a < 16'h6000) w = 2;
    else if (a >= 16'h6000 && a < 16'h8000) w = 3;
    else if (a >= 16'hA000 && a < 16'hC000) w = 4;
    if (w < 0) return e;
    if (off[w]) begin e.tag = "R4"; return e; end
    o = a[14:0] ^ {f14, f13, 13'd0};
    case (m)
      3'b000: begin
        e.tag = "R5";
        if (w != 4) return e;
        e.hit = 1;
        if (wr) begin e.sce = 1; e.we = 1; e.addr = 19'h0E000 + 19'(a[12:0]); end
        else begin e.fce = 1; e.addr = 19'h06000 + 19'(a[12:0]); end
      end
      3'b001: begin
        e.tag = "R9"; e.hit = 1; e.fce = 1; e.we = wr;
        e.addr = (19'(inf[3:0]) << 15) + 19'(o);
      end
      3'b100, 3'b110: begin
        e.hit = 1;
        if (w == 0) begin
          e.tag = "R8";
          if (wr && !inf[0]) return e;
          bk = 0;
        end else if (m == 3'b100) begin
          e.tag = "R6"; bk = (wr && inf[w]) ? 2 : 1;
        end else begin
          e.tag = "R7"; bk = (!wr && inf[w]) ? 2 : 1;
        end
        e.sce = 1; e.we = wr;
        e.addr = (19'(bk) << 15) + 19'(o);
      end
      default: e.tag = "R11";
    endcase
    return e;
  endfunction

  task automatic drive(logic [15:0] a, logic wr, logic [2:0] m, logic [4:0] inf,
                       logic [4:0] off, logic f13, logic f14);
    @(negedge clk);
    cpu_addr = a; cpu_wr = wr; mode_sel = m; info_bits = inf; blk_off = off;
    flip_a13 = f13; flip_a14 = f14;
    sb.push_back(model(a, wr, m, inf, off, f13, f14));
  endtask

  task automatic chk(string tag, bit ok, string what);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: %s", tag, what); end
  endtask

  // monitor: pops one expected item per edge, sampled 1 ns after the edge (R2)
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, {hit, sram_ce, flash_ce, mem_we, mem_addr} == {e.hit, e.sce, e.fce, e.we, e.addr},
          $sformatf("R2 got hit=%b sce=%b fce=%b we=%b addr=%h exp hit=%b sce=%b fce=%b we=%b addr=%h",
                    hit, sram_ce, flash_ce, mem_we, mem_addr, e.hit, e.sce, e.fce, e.we, e.addr));
      chk("R12", !(sram_ce && flash_ce) && (!mem_we || sram_ce || flash_ce) &&
          (sram_ce || flash_ce || mem_addr == 19'd0),
          $sformatf("got sce=%b fce=%b we=%b addr=%h exp exclusive", sram_ce, flash_ce, mem_we, mem_addr));
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: drive a hitting access during reset, outputs must stay 0
    cpu_addr = 16'hA123; cpu_wr = 1; mode_sel = 3'b100; info_bits = 5'h1F;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {hit, sram_ce, flash_ce, mem_we, mem_addr} == 23'd0,
        $sformatf("got %b%b%b%b %h exp all zero", hit, sram_ce, flash_ce, mem_we, mem_addr));
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1", {hit, sram_ce, flash_ce, mem_we} == 4'd0,
        $sformatf("got hit=%b exp 0 before first edge", hit));

    // R5 boot mode
    drive(16'hA000, 0, 3'b000, 5'h00, 5'h00, 0, 0);
    drive(16'hBFFF, 1, 3'b000, 5'h00, 5'h00, 1, 1);
    drive(16'h2000, 0, 3'b000, 5'h00, 5'h00, 0, 0);
    drive(16'h0400, 1, 3'b000, 5'h01, 5'h00, 0, 0);
    drive(16'hA555, 1, 3'b000, 5'h00, 5'h10, 0, 0);   // R4
    // R6 / R7 steering, each window
    for (int w = 0; w < 5; w++) begin
      logic [15:0] base;
      base = (w == 0) ? 16'h0400 : (w == 4) ? 16'hA000 : 16'(w * 16'h2000);
      for (int rw = 0; rw < 2; rw++) begin
        drive(base + 16'h0011, 1'(rw), 3'b100, 5'h1F, 5'h00, 0, 0);
        drive(base + 16'h0022, 1'(rw), 3'b100, 5'h00, 5'h00, 0, 0);
        drive(base + 16'h0033, 1'(rw), 3'b110, 5'h1F, 5'h00, 0, 0);
        drive(base + 16'h0044, 1'(rw), 3'b110, 5'h00, 5'h00, 0, 0);
      end
    end
    // R8 window 0 protection boundary
    drive(16'h0FFF, 1, 3'b100, 5'h1E, 5'h00, 0, 0);
    drive(16'h0FFF, 1, 3'b110, 5'h01, 5'h00, 0, 0);
    drive(16'h03FF, 0, 3'b100, 5'h1F, 5'h00, 0, 0);
    // R9 flash banks
    drive(16'h0400, 1, 3'b001, 5'h0F, 5'h00, 0, 0);
    drive(16'h7FFF, 0, 3'b001, 5'h05, 5'h00, 0, 1);
    // R10 flips in RAM mode
    drive(16'h6ABC, 0, 3'b110, 5'h08, 5'h00, 1, 0);
    drive(16'h2ABC, 1, 3'b100, 5'h02, 5'h00, 1, 1);
    // R11 undefined modes
    drive(16'h2000, 1, 3'b010, 5'h1F, 5'h00, 0, 0);
    drive(16'hA000, 0, 3'b011, 5'h1F, 5'h00, 0, 0);
    drive(16'h4000, 1, 3'b101, 5'h1F, 5'h00, 0, 0);
    drive(16'h0500, 0, 3'b111, 5'h1F, 5'h00, 0, 0);
    // R3 gaps
    drive(16'h1000, 0, 3'b001, 5'h00, 5'h00, 0, 0);
    drive(16'h8000, 1, 3'b100, 5'h00, 5'h00, 0, 0);
    drive(16'hC000, 0, 3'b110, 5'h00, 5'h00, 0, 0);
    // mixed sweep
    for (int i = 0; i < 600; i++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 7));
      if (i % 2 == 0) m = (i % 8 == 0) ? 3'b000 : (i % 8 == 2) ? 3'b001 : (i % 8 == 4) ? 3'b100 : 3'b110;
      drive(16'($urandom), 1'($urandom), m, 5'($urandom), (i % 3 == 0) ? 5'($urandom) : 5'h00,
            1'($urandom), 1'($urandom));
    end
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule